// File: doc/BRIEF.md
# Parallel-In Serial-Out Cascadable FIFO

This block buffers 16-bit words that arrive on a parallel write port and sends each word out as a bit stream. It runs on one system clock. A serial shift strobe, `shift_en`, acts as the serial output clock. The serial output is three-state, so several instances can hang on one serial line. Only the instance that holds a read token drives the line. The token moves between instances on a single-wire ring: each instance's `tok_out` goes to the next instance's `tok_in`, and the last instance wraps back to the first. Width chains use this ring to spread one serial word across devices, and depth chains use it to take whole words from each device in turn.

The `role_order` pin has two jobs. Its level at the last clock edge of reset picks the chain role: low means this instance is the first in the chain and starts with the token, high means it waits for one. After reset, in width-chain builds, its level at the edge where a word is loaded into the shifter picks the bit order. The build parameter `MODE` selects a width-chain or depth-chain instance. A depth-chain instance always sends the low bit first.

The control is a three-state machine:
- `ST_WAIT`: no token.
- `ST_PARK`: holds the token but has nothing to send.
- `ST_SEND`: drives the line and shifts.

Its transitions are:
- **take-and-send**: WAIT to SEND, on `tok_in` while words are stored.
- **take-and-park**: WAIT to PARK, on `tok_in` while empty.
- **data-arrives**: PARK to SEND, once the count is non-zero.
- **hand-off**: SEND to WAIT, on the strobe that consumes the last bit.

Top module: `piso_chain_fifo`

## Requirements
- R1: After reset, `empty`=1, `half_full`=0, `full`=0, `ser_oe`=0 and `tok_out`=0. Both pointers start at location zero, so the first word written is the first word sent. `DEPTH` is 256, 512 or 1024 words of 16 bits.
- R2: `empty` is high when the stored count is 0. `half_full` is high when the count is greater than `DEPTH`/2. `full` is high when the count equals `DEPTH`. The flags show the count from the clock edge that accepted a write or consumed a word.
- R3: A write while `full` is high is dropped. The count and the flags do not change, and the dropped word is never sent.
- R4: If `role_order` is high at the last reset edge, the instance waits. It keeps `ser_oe` low, even while holding data, until it receives a token on `tok_in`.
- R5: `ser_out` is driven, with `ser_oe`=1, only in the SEND state. At all other times `ser_oe`=0 and `ser_out` is high impedance.
- R6: While sending, `ser_out` shows the current bit. Each clock edge with `shift_en` high moves to the next bit, and without the strobe the bit holds. Sixteen strobes finish a word and remove it from the count at the sixteenth strobe's edge. Words leave in write order.
- R7: In a width-chain instance, `role_order` low at the load edge sends bit 0 first and bit 15 last. `role_order` high sends bit 15 first and bit 0 last.
- R8: A depth-chain instance always sends bit 0 first, whatever the level on `role_order`.
- R9: After the edge that consumes a word's last bit, `tok_out` is high for exactly one cycle and `ser_oe` is already low.
- R10: A waiting instance that sees `tok_in` high at a clock edge takes the token. If it holds data, `ser_oe` is high right after that edge, showing the first bit of its oldest word.
- R11: A token holder that is empty keeps `ser_oe` low, ignores `shift_en` and does not pulse `tok_out`. One edge after its count turns non-zero, it starts driving the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| role_order | input | 1 | Chain role, sampled during reset; bit order at word load (width chain) |
| wr_en | input | 1 | Write strobe for the parallel port |
| wr_data | input | 16 | Parallel word to store |
| shift_en | input | 1 | Serial output strobe; one bit per strobed edge |
| tok_in | input | 1 | Token input from the previous instance in the ring |
| ser_out | output | 1 | Three-state serial data |
| ser_oe | output | 1 | High while this instance drives `ser_out` |
| tok_out | output | 1 | One-cycle token pulse to the next instance |
| empty | output | 1 | No words stored |
| half_full | output | 1 | More than half the depth in use |
| full | output | 1 | Every location in use |

## Verification
A wrong word count appears on the flags the edge after the write or final strobe that changed it. A missed pointer step shows up later as an out-of-order or repeated bit stream. A wrong state shows up within one cycle on `ser_oe` or `tok_out`: it either drives the line without the token or holds the token and never sends. A latched bit order that is wrong, or a shifter that skips a strobe, corrupts the serial stream on the very next strobe, and the bit-by-bit scoreboard catches it there.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_PARK = 2'd1,
        ST_SEND = 2'd2
    } tok_state_e;

    typedef enum logic {
        CHAIN_WIDTH = 1'b0,
        CHAIN_DEPTH = 1'b1
    } chain_mode_e;

endpackage

// File: rtl/piso_store.sv
module piso_store #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic              empty,
    output logic              half,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FILL_MAX  = CW'(DEPTH);
    localparam logic [CW-1:0] FILL_HALF = CW'(DEPTH / 2);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     fill;
    logic              accept;
    logic              take;

    assign accept = wr_req && !full;
    assign take   = pop && !empty;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (take) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            fill <= fill + CW'(accept) - CW'(take);
        end
    end

    always_comb begin
        empty = (fill == '0);
        full  = (fill == FILL_MAX);
        half  = (fill > FILL_HALF);
    end

    assign head_word = mem[rd_ptr];

endmodule

// File: rtl/piso_serializer.sv
module piso_serializer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              lsb_first,
    input  logic [WORD_W-1:0] word,
    output logic              ser_bit,
    output logic              last_bit
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_IDX = BW'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [BW-1:0]     idx;
    logic              lsb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            idx   <= '0;
            lsb_q <= 1'b1;
        end else if (load) begin
            sreg  <= word;
            idx   <= '0;
            lsb_q <= lsb_first;
        end else if (step) begin
            idx  <= idx + 1'b1;
            sreg <= lsb_q ? (sreg >> 1) : (sreg << 1);
        end
    end

    assign ser_bit  = lsb_q ? sreg[0] : sreg[WORD_W-1];
    assign last_bit = (idx == LAST_IDX);

endmodule

// File: rtl/piso_token_fsm.sv
module piso_token_fsm
    import piso_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       role_pin,
    input  logic       tok_in,
    input  logic       empty,
    input  logic       sclk_en,
    input  logic       last_bit,
    output logic       load,
    output logic       step,
    output logic       pop,
    output logic       drive,
    output logic       tok_out,
    output tok_state_e state_o
);
    tok_state_e state_q;
    tok_state_e state_d;
    logic       tok_q;

    // state register; the role pin picks the post-reset state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= role_pin ? ST_WAIT : ST_PARK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (tok_in) begin
                    state_d = empty ? ST_PARK : ST_SEND;
                end
            end
            ST_PARK: begin
                if (!empty) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sclk_en && last_bit) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        step  = 1'b0;
        pop   = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            ST_WAIT: load = tok_in && !empty;
            ST_PARK: load = !empty;
            ST_SEND: begin
                drive = 1'b1;
                step  = sclk_en;
                pop   = sclk_en && last_bit;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q <= 1'b0;
        end else begin
            tok_q <= pop;
        end
    end

    assign tok_out = tok_q;
    assign state_o = state_q;

endmodule

// File: rtl/piso_chain_fifo.sv
module piso_chain_fifo
    import piso_pkg::*;
#(
    parameter int          DEPTH  = 256,
    parameter int          WORD_W = 16,
    parameter chain_mode_e MODE   = CHAIN_WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              role_order,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              shift_en,
    input  logic              tok_in,
    output wire               ser_out,
    output logic              ser_oe,
    output logic              tok_out,
    output logic              empty,
    output logic              half_full,
    output logic              full
);
    logic [WORD_W-1:0] head_word;
    logic              load;
    logic              step;
    logic              pop;
    logic              drive;
    logic              lsb_sel;
    logic              ser_bit;
    logic              last_bit;
    tok_state_e        fsm_state;

    generate
        if (MODE == CHAIN_DEPTH) begin : g_depth_order
            assign lsb_sel = 1'b1;
        end else begin : g_width_order
            assign lsb_sel = !role_order;
        end
    endgenerate

    piso_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_en),
        .wr_data   (wr_data),
        .pop       (pop),
        .head_word (head_word),
        .empty     (empty),
        .half      (half_full),
        .full      (full)
    );

    piso_serializer #(
        .WORD_W (WORD_W)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .lsb_first (lsb_sel),
        .word      (head_word),
        .ser_bit   (ser_bit),
        .last_bit  (last_bit)
    );

    piso_token_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .role_pin (role_order),
        .tok_in   (tok_in),
        .empty    (empty),
        .sclk_en  (shift_en),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .pop      (pop),
        .drive    (drive),
        .tok_out  (tok_out),
        .state_o  (fsm_state)
    );

    assign ser_oe  = drive;
    assign ser_out = drive ? ser_bit : 1'bz;

endmodule

// File: rtl/piso_chain_fifo_chk.sv
module piso_chain_fifo_chk
    import piso_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       shift_en,
    input logic       tok_in,
    input logic       tok_out,
    input logic       ser_oe,
    input logic       empty,
    input logic       half_full,
    input logic       full,
    input tok_state_e state
);
    initial begin
        a_depth_legal_r1 : assert (DEPTH == 256 || DEPTH == 512 || DEPTH == 1024);
    end

    p_flags_exclusive_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_full_has_half_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half_full);

    p_no_overflow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ser_oe) |=> full);

    p_hiz_when_empty_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !ser_oe);

    p_hold_bit_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && !shift_en) |=> ser_oe);

    p_tok_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);

    p_tok_after_send_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> ($past(ser_oe) && !ser_oe));

    p_take_token_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && tok_in && !empty) |=> ser_oe);

    p_park_release_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK && !empty) |=> ser_oe);

    p_park_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARK) |=> !tok_out);

endmodule

bind piso_chain_fifo piso_chain_fifo_chk #(
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .tok_in    (tok_in),
    .tok_out   (tok_out),
    .ser_oe    (ser_oe),
    .empty     (empty),
    .half_full (half_full),
    .full      (full),
    .state     (fsm_state)
);

// File: tb/piso_chain_fifo_tb.sv
module piso_chain_fifo_tb;
    import piso_pkg::*;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        role_w = 1'b1, role_d = 1'b0;
    logic        wr_w = 1'b0, wr_d = 1'b0;
    logic [15:0] data_w = '0, data_d = '0;
    logic        sh_w = 1'b0, sh_d = 1'b0;
    logic        tin_w = 1'b0, tin_d = 1'b0;
    wire         ser_w, ser_d;
    logic        oe_w, oe_d, tout_w, tout_d;
    logic        e_w, h_w, f_w, e_d, h_d, f_d;

    int n_vec = 0;
    int n_bad = 0;
    int cnt_w = 0;
    int tok_cnt_d = 0;
    bit q_w[$];
    bit q_d[$];

    always #2.5 clk = ~clk;

    piso_chain_fifo #(.DEPTH(DEPTH), .MODE(CHAIN_WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .role_order(role_w), .wr_en(wr_w),
        .wr_data(data_w), .shift_en(sh_w), .tok_in(tin_w), .ser_out(ser_w),
        .ser_oe(oe_w), .tok_out(tout_w), .empty(e_w), .half_full(h_w), .full(f_w)
    );

    piso_chain_fifo #(.DEPTH(DEPTH), .MODE(CHAIN_DEPTH)) u_dep (
        .clk(clk), .rst_n(rst_n), .role_order(role_d), .wr_en(wr_d),
        .wr_data(data_d), .shift_en(sh_d), .tok_in(tin_d), .ser_out(ser_d),
        .ser_oe(oe_d), .tok_out(tout_d), .empty(e_d), .half_full(h_d), .full(f_d)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_bits(input bit to_dep, input logic [15:0] w, input bit lsb);
        for (int k = 0; k < 16; k++) begin
            bit b = lsb ? w[k] : w[15-k];
            if (to_dep) q_d.push_back(b);
            else        q_w.push_back(b);
        end
    endtask

    task automatic flags_w(input string req);
        check(e_w == (cnt_w == 0),         req, "empty",     int'(e_w), int'(cnt_w == 0));
        check(h_w == (cnt_w > DEPTH / 2),  req, "half_full", int'(h_w), int'(cnt_w > DEPTH / 2));
        check(f_w == (cnt_w == DEPTH),     req, "full",      int'(f_w), int'(cnt_w == DEPTH));
    endtask

    // driver: write one word; the scoreboard gets its bits if it should be stored
    task automatic write_w(input logic [15:0] w, input bit lsb, input bit stored);
        @(posedge clk); #1;
        wr_w = 1'b1; data_w = w;
        @(posedge clk); #1;
        wr_w = 1'b0;
        if (stored) begin
            push_bits(1'b0, w, lsb);
            cnt_w++;
        end
    endtask

    task automatic write_d(input logic [15:0] w);
        @(posedge clk); #1;
        wr_d = 1'b1; data_d = w;
        push_bits(1'b1, w, 1'b1);
        @(posedge clk); #1;
        wr_d = 1'b0;
    endtask

    task automatic send_one_w(input bit dir);
        @(posedge clk); #1;
        role_w = dir; tin_w = 1'b1;
        @(posedge clk); #1;
        tin_w = 1'b0;
        check(oe_w == 1'b1, "R10", "drive after token", int'(oe_w), 1);
        sh_w = 1'b1;
        repeat (16) @(posedge clk);
        #1;
        sh_w = 1'b0;
        cnt_w--;
        check(oe_w == 1'b0,  "R9", "released after last bit", int'(oe_w), 0);
        check(tout_w == 1'b1, "R9", "token pulse", int'(tout_w), 1);
        @(posedge clk); #1;
        check(tout_w == 1'b0, "R9", "token pulse width", int'(tout_w), 0);
    endtask

    // monitor: compare every strobed bit with the scoreboard
    always @(negedge clk) begin
        bit e;
        if (rst_n) begin
            if (oe_w && sh_w) begin
                if (q_w.size() == 0) begin
                    check(1'b0, "R6", "unexpected width bit", int'(ser_w), -1);
                end else begin
                    e = q_w.pop_front();
                    check(ser_w == e, "R7", "width-chain bit", int'(ser_w), int'(e));
                end
            end
            if (oe_d && sh_d) begin
                if (q_d.size() == 0) begin
                    check(1'b0, "R6", "unexpected depth bit", int'(ser_d), -1);
                end else begin
                    e = q_d.pop_front();
                    check(ser_d == e, "R8", "depth-chain bit", int'(ser_d), int'(e));
                end
            end
            if (tout_d) tok_cnt_d++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        flags_w("R1");
        check(oe_w == 1'b0 && tout_w == 1'b0, "R1", "width idle", int'(oe_w), 0);
        check(e_d == 1'b1 && h_d == 1'b0 && f_d == 1'b0, "R1", "depth flags",
              int'({e_d, h_d, f_d}), 4);

        // R11 parked holder ignores strobes
        sh_d = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(oe_d == 1'b0 && tout_d == 1'b0, "R11", "parked quiet",
                  int'({oe_d, tout_d}), 0);
        end

        // R8 + R11: pin high must not flip the order of a depth instance
        role_d = 1'b1;
        write_d(16'hA5C3);
        repeat (22) @(posedge clk);
        #1;
        check(tok_cnt_d == 1, "R9", "depth token pulses", tok_cnt_d, 1);
        check(q_d.size() == 0, "R6", "depth word fully sent", q_d.size(), 0);
        check(e_d == 1'b1, "R2", "depth empty after send", int'(e_d), 1);

        // R4 after handing off, a waiting instance holds data silently
        write_d(16'h0F0F);
        repeat (4) begin
            @(negedge clk);
            check(oe_d == 1'b0, "R4", "depth waiter silent", int'(oe_d), 0);
        end
        @(posedge clk); #1;
        tin_d = 1'b1;
        @(posedge clk); #1;
        tin_d = 1'b0;
        check(oe_d == 1'b1, "R10", "depth takes token", int'(oe_d), 1);
        repeat (20) @(posedge clk);
        #1;
        sh_d = 1'b0;
        check(q_d.size() == 0 && tok_cnt_d == 2, "R6", "depth second word",
              q_d.size() + tok_cnt_d, 2);

        // R4 width instance started as waiter: data stored, no drive, strobes ignored
        write_w(16'h1357, 1'b1, 1'b1);
        flags_w("R2");
        write_w(16'hC0DE, 1'b0, 1'b1);
        write_w(16'h8001, 1'b1, 1'b1);
        flags_w("R2");
        sh_w = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(oe_w == 1'b0, "R4", "waiter silent", int'(oe_w), 0);
            check(oe_w == 1'b0 || 1'b0, "R5", "no drive without token", int'(oe_w), 0);
        end
        #1 sh_w = 1'b0;
        // R7 orders: LSB first, MSB first, LSB first
        send_one_w(1'b0);
        flags_w("R2");
        send_one_w(1'b1);
        send_one_w(1'b0);
        flags_w("R2");

        // R2 thresholds while filling
        for (int i = 0; i < DEPTH; i++) begin
            write_w(16'(i * 97 + 5), (i % 2) == 0, 1'b1);
            if (i == DEPTH / 2 - 1 || i == DEPTH / 2 || i == DEPTH - 1) flags_w("R2");
        end
        // R3 write while full
        write_w(16'hDEAD, 1'b1, 1'b0);
        flags_w("R3");
        for (int i = 0; i < DEPTH; i++) begin
            send_one_w((i % 2) != 0);
        end
        flags_w("R2");
        check(q_w.size() == 0, "R6", "all words sent", q_w.size(), 0);

        // R3: the dropped word is not there; R11 holder parks
        @(posedge clk); #1;
        tin_w = 1'b1;
        @(posedge clk); #1;
        tin_w = 1'b0;
        sh_w = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(oe_w == 1'b0, "R3", "dropped word absent", int'(oe_w), 0);
        end
        #1 sh_w = 1'b0;

        // R11 parked holder sends a word one edge after it arrives
        role_w = 1'b0;
        write_w(16'h2468, 1'b1, 1'b1);
        check(oe_w == 1'b0, "R11", "not yet driving", int'(oe_w), 0);
        @(posedge clk); #1;
        check(oe_w == 1'b1, "R11", "driving after data", int'(oe_w), 1);
        sh_w = 1'b1;
        repeat (16) @(posedge clk);
        #1;
        sh_w = 1'b0;
        cnt_w--;
        check(tout_w == 1'b1, "R9", "token after parked word", int'(tout_w), 1);
        flags_w("R2");
        check(q_w.size() == 0, "R6", "scoreboard drained", q_w.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule